// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Compare Alarm

This block keeps wall time as a free-running binary count of seconds that advances on a one-second tick pulse supplied from outside. A host reaches it over a narrow byte bus. Each access carries an address, one data byte, and a write or read strobe. The block has a control byte, an alarm status byte, a staging window for loading a new time, a live read window for the running count, and a compare window holding the alarm time.

A new time is loaded in a fixed sequence. Software first writes 0x00 to the low byte so that no carry can ripple while the upper bytes change. It then writes the three upper bytes into staging registers. Finally it writes the real low byte, and that write moves every staged byte into the counter at once.

Reads are not snapshotted. Each byte comes from the live count in the cycle of its access, so software that sees the low byte shrink between reads re-reads the whole value. When the count reaches the compare value while the alarm is enabled, a sticky status bit is set and drives a level alarm output. The output stays high until software clears the status bit.

Top module: `secs_rtc`

## Requirements
- R1: After reset the counter, the three staging bytes, the four compare bytes, the run bit, the alarm-enable bit and the alarm status are all zero, and every offset 0x0 to 0xF reads 0x00 with the alarm output low.
- R2: With the run bit (bit 7 of offset 0x00) set, each tick pulse adds one to the 32-bit count, wrapping from 0xFFFFFFFF to 0. The count reads back little-endian at offsets 0x06 (bits 7:0) through 0x09 (bits 31:24).
- R3: With the run bit clear, ticks leave the count unchanged.
- R4: Writes to offsets 0x03, 0x04 and 0x05 only fill staging bytes 1, 2 and 3 and do not change the count.
- R5: A write to offset 0x02 loads {staged byte 3, byte 2, byte 1, written byte} into the count in that same cycle, whatever the run bit. A tick in that cycle is dropped.
- R6: The alarm-enable bit is bit 1 of offset 0x00. While it is clear, a count equal to the compare value raises no alarm.
- R7: When the count becomes equal to the compare value (offsets 0x0A to 0x0D, little-endian) with the alarm enabled, status bit 0 of offset 0x01 and the alarm output go high one cycle later. They stay high until cleared, and a match that persists does not set them again after a clear.
- R8: Writing a byte with bit 0 equal to 0 to offset 0x01 clears the status and drops the alarm output. Writing bit 0 equal to 1 has no effect.
- R9: A read strobe returns its byte on the read data output one cycle later, taken from the live value before that clock edge, and the output holds until the next read.
- R10: Reads of the staging window 0x02 to 0x05 and of 0x0E and 0x0F return 0x00. Writes to the live window 0x06 to 0x09 are ignored. The compare bytes read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| addr_i | input | 4 | Register offset of the access |
| wdata_i | input | 8 | Write data byte |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data byte |
| alarm_irq_o | output | 1 | Level alarm, high while status is set |

## Verification
The bench goes after carry boundaries: low-byte overflow, a full wrap past 0xFFFFFFFF, and a run of ticks across a byte edge. A design that put bytes in the wrong order or lost the carry would return wrong readback there. It drives a tick in the same cycle as the committing low-byte write, where a design that did not drop the tick would read one too high. It also clears the alarm while the count still matches the compare value, where a level-sensitive design would raise the output again at once. Checks for a dead run bit, a dead enable bit, a write-one that clears, and stray decodes into the live window or unmapped offsets each fail on a design with that mistake.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_ACTL = 1;
  localparam int OFS_WR   = 2;
  localparam int OFS_RD   = 6;
  localparam int OFS_ALM  = 10;
  localparam int RUN_BIT  = 7;
  localparam int AEN_BIT  = 1;
  localparam int STS_BIT  = 0;
endpackage

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst)                count_o <= '0;
    else if (load_i)        count_o <= load_val_i;
    else if (run_i && tick_i) count_o <= count_o + 1'b1;
  end

  p_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && !load_i) |=> (count_o == $past(count_o) + 1'b1));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> $stable(count_o));
  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (count_o == $past(load_val_i)));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] count_i,
  input  logic [WIDTH-1:0] cmp_i,
  output logic             status_o
);
  logic match, match_q;
  assign match = en_i && (count_i == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q  <= 1'b0;
      status_o <= 1'b0;
    end else begin
      match_q <= match;
      if (match && !match_q) status_o <= 1'b1;
      else if (clr_i)        status_o <= 1'b0;
    end
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (status_o && !clr_i) |=> status_o);
  p_enable_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o) |-> $past(en_i));
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc #(
  parameter int BYTES  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [7:0]        rdata_o,
  output logic              alarm_irq_o
);
  import rtc_pkg::*;
  localparam int WIDTH = BYTES * 8;

  logic             run_q, aen_q, status;
  logic [WIDTH-1:8] stage_q;
  logic [WIDTH-1:0] alarm_q, count;
  logic             load, clr;
  logic [7:0]       rd_next;

  assign load = wr_en_i && (addr_i == ADDR_W'(OFS_WR));
  assign clr  = wr_en_i && (addr_i == ADDR_W'(OFS_ACTL)) && !wdata_i[STS_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      aen_q   <= 1'b0;
      stage_q <= '0;
      alarm_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(OFS_CTRL)) begin
        run_q <= wdata_i[RUN_BIT];
        aen_q <= wdata_i[AEN_BIT];
      end
      for (int i = 1; i < BYTES; i++)
        if (addr_i == ADDR_W'(OFS_WR + i)) stage_q[8*i +: 8] <= wdata_i;
      for (int i = 0; i < BYTES; i++)
        if (addr_i == ADDR_W'(OFS_ALM + i)) alarm_q[8*i +: 8] <= wdata_i;
    end
  end

  rtc_count #(.WIDTH(WIDTH)) i_count (
    .clk(clk), .rst(rst), .run_i(run_q), .tick_i(tick_i),
    .load_i(load), .load_val_i({stage_q, wdata_i}), .count_o(count)
  );

  rtc_alarm #(.WIDTH(WIDTH)) i_alarm (
    .clk(clk), .rst(rst), .en_i(aen_q), .clr_i(clr),
    .count_i(count), .cmp_i(alarm_q), .status_o(status)
  );

  always_comb begin
    rd_next = 8'h00;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rd_next[RUN_BIT] = run_q;
      rd_next[AEN_BIT] = aen_q;
    end
    if (addr_i == ADDR_W'(OFS_ACTL)) rd_next[STS_BIT] = status;
    for (int i = 0; i < BYTES; i++) begin
      if (addr_i == ADDR_W'(OFS_RD + i))  rd_next = count[8*i +: 8];
      if (addr_i == ADDR_W'(OFS_ALM + i)) rd_next = alarm_q[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= 8'h00;
    else if (rd_en_i) rdata_o <= rd_next;
  end

  assign alarm_irq_o = status;

  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i >= ADDR_W'(OFS_ALM + BYTES)) |=> (rdata_o == 8'h00));
  p_rdhold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/test_secs_rtc.sv
module test_secs_rtc;
  logic clk = 0, rst = 1, tick = 0, wr = 0, rd = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  secs_rtc i_secs_rtc (
    .clk(clk), .rst(rst), .tick_i(tick), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr), .rd_en_i(rd), .rdata_o(rdata), .alarm_irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr8(logic [3:0] a, logic [7:0] d, logic tk = 0);
    @(negedge clk); addr = a; wdata = d; wr = 1; tick = tk;
    @(negedge clk); wr = 0; tick = 0;
  endtask

  task automatic rd8(logic [3:0] a, output logic [7:0] d, input logic tk = 0);
    @(negedge clk); addr = a; rd = 1; tick = tk;
    @(negedge clk); rd = 0; tick = 0; d = rdata;
  endtask

  task automatic rd32(logic [3:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd8(base + 4'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic load(logic [31:0] v, logic tk = 0);
    wr8(4'h2, 8'h00);
    wr8(4'h3, v[15:8]); wr8(4'h4, v[23:16]); wr8(4'h5, v[31:24]);
    wr8(4'h2, v[7:0], tk);
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [31:0] v, w;
    logic [31:0] vals [4] = '{32'h12345678, 32'hA5A50001, 32'hFFFFFFFF, 32'h000000FF};
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state sweep over all offsets
    for (int a = 0; a < 16; a++) begin
      rd8(4'(a), b);
      chk("R1", {24'h0, b}, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R5 / R4: load sweep with run off
    foreach (vals[k]) begin
      load(vals[k]); rd32(4'h6, v);
      chk("R5 load", v, vals[k]);
    end
    wr8(4'h2, 8'h00); rd32(4'h6, w);
    wr8(4'h3, 8'h11); wr8(4'h4, 8'h22); wr8(4'h5, 8'h33);
    rd32(4'h6, v);
    chk("R4 staging only", v, w);

    // R2: counting with carry and wrap
    wr8(4'h0, 8'h80);
    load(32'h000000FF); pulse(); rd32(4'h6, v); chk("R2 carry", v, 32'h00000100);
    load(32'hFFFFFFFF); pulse(); rd32(4'h6, v); chk("R2 wrap", v, 32'h0);
    load(32'h000001FD);
    for (int t = 1; t <= 5; t++) begin
      pulse(); rd32(4'h6, v);
      chk("R2 sweep", v, 32'h000001FD + 32'(t));
    end
    // R5: tick in commit cycle dropped
    load(32'h00C0FFEE, 1'b1); rd32(4'h6, v); chk("R5 tick dropped", v, 32'h00C0FFEE);
    // R9: live read, value from before the edge
    load(32'h00000010);
    rd8(4'h6, b, 1'b1); chk("R9 pre-edge", {24'h0, b}, 32'h10);
    rd8(4'h6, b); chk("R9 live", {24'h0, b}, 32'h11);
    rd8(4'h0, b); chk("R2 ctrl readback", {24'h0, b}, 32'h80);

    // R3: run off holds
    wr8(4'h0, 8'h00); load(32'h00000500);
    repeat (3) pulse();
    rd32(4'h6, v); chk("R3 hold", v, 32'h00000500);

    // R10: read window writes ignored, unmapped zero, alarm bytes R/W
    wr8(4'h7, 8'h55); rd32(4'h6, v); chk("R10 ro window", v, 32'h00000500);
    foreach (vals[k]) begin
      for (int i = 0; i < 4; i++) wr8(4'hA + 4'(i), vals[k][8*i +: 8]);
      rd32(4'hA, v); chk("R10 alarm rw", v, vals[k]);
    end
    for (int a = 2; a < 6; a++) begin rd8(4'(a), b); chk("R10 wr window", {24'h0, b}, 32'h0); end
    rd8(4'hE, b); chk("R10 0xE", {24'h0, b}, 32'h0);
    rd8(4'hF, b); chk("R10 0xF", {24'h0, b}, 32'h0);

    // R6: alarm disabled, match ignored
    for (int i = 0; i < 4; i++) wr8(4'hA + 4'(i), (i == 0) ? 8'd102 : 8'd0);
    wr8(4'h0, 8'h80); load(32'd100);
    pulse(); pulse(); @(negedge clk);
    chk("R6 no irq", {31'h0, irq}, 32'h0);
    rd8(4'h1, b); chk("R6 no status", {24'h0, b}, 32'h0);

    // R7: enabled alarm
    load(32'd100); wr8(4'h0, 8'h82);
    pulse(); @(negedge clk); chk("R7 before match", {31'h0, irq}, 32'h0);
    pulse(); @(negedge clk); chk("R7 match", {31'h0, irq}, 32'h1);
    rd8(4'h1, b); chk("R7 status", {24'h0, b}, 32'h1);
    pulse(); @(negedge clk); chk("R7 sticky", {31'h0, irq}, 32'h1);
    // R8: write 1 no effect, write 0 clears
    wr8(4'h1, 8'h01); chk("R8 write one", {31'h0, irq}, 32'h1);
    wr8(4'h1, 8'h00); chk("R8 clear", {31'h0, irq}, 32'h0);
    // R7: re-arm on new match, then clear while still matching
    load(32'd102); @(negedge clk); chk("R7 rematch", {31'h0, irq}, 32'h1);
    wr8(4'h0, 8'h02); wr8(4'h1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 no refire", {31'h0, irq}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule